// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block sends the header that a LIN master puts on the bus before a frame's response. Software sets the start bit, and the block shapes the header on a serial output, one bit time per group of oversampling ticks. The header is one of three kinds: a dominant break alone, a break followed by the sync byte, or a break, the sync byte and a protected identifier. The break length can be set from 8 to 15 bit times. The identifier's two parity bits are computed in hardware from the six ID bits that software supplies.

While a header is on the wire, the block can read back the bus at the middle of every bit and raise a sticky error flag when the bus level differs from the level being driven. When the last bit of the chosen header has gone out, the start bit clears itself and a sticky completion flag is raised. Both flags clear on a write of 1. The block reads its configuration once, when it accepts a start, and it ignores a second start request while a header is in progress.

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset, `txd` is 1 and `trig`, `done` and `berr` are 0. Reset in the middle of a header returns the block to this state.
- R2: One bit time is `OVS` (default 4) pulses of `baud_tick`. The break drives `txd` low for `brk_ext + 8` bit times.
- R3: `hdr_sel` 00 sends the break only, with no delimiter after it. Code 11 behaves the same as code 10.
- R4: With `hdr_sel` 01, the break is followed by one high delimiter bit, then a 10-bit frame for the byte 0x55: a low start bit, eight data bits LSB first, and a high stop bit.
- R5: With `hdr_sel` 10, a second 10-bit frame follows the sync frame and carries PID = {P1, P0, ident[5:0]}, where P0 = id0^id1^id2^id4 and P1 = ~(id1^id3^id4^id5).
- R6: `trig` rises in the cycle after a start write while idle and stays high until the final tick of the header's last bit. In that same edge it falls and `done` is set.
- R7: A start write while `trig` is high has no effect. The header in progress, including its configuration, continues unchanged.
- R8: When `berr_en` is 1 and a header is in progress, a difference between `rxd` and `txd` at the mid-bit tick (tick index `OVS/2` within a bit) sets `berr`. `berr` then stays set.
- R9: `berr` is not set while `berr_en` is 0, and it is not set while the block is idle.
- R10: A 1 on `clr_done` or `clr_berr` clears the matching flag. If a set and a clear happen in the same cycle, the set wins.
- R11: While idle, `txd` is high and `baud_tick` pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling tick, `OVS` per bit time |
| start_wr | input | 1 | Write of 1 to the start bit |
| hdr_sel | input | 2 | Header kind: 00 break, 01 +sync, 10/11 +sync+PID |
| brk_ext | input | 3 | Break length minus 8, in bit times |
| ident | input | 6 | Identifier bits 0..5 |
| berr_en | input | 1 | Enables bus read-back comparison |
| clr_done | input | 1 | Write-1 clear of `done` |
| clr_berr | input | 1 | Write-1 clear of `berr` |
| rxd | input | 1 | Read-back of the bus level |
| txd | output | 1 | Serial header output |
| trig | output | 1 | Start bit state; high while a header is sent |
| done | output | 1 | Sticky header-complete flag |
| berr | output | 1 | Sticky bit-error flag |

## Verification
The embedded properties check several rules on every cycle: the tick counter stays in range, the break counter stays within the captured length, the captured configuration holds across a rejected start, the line stays high when idle, the error flag stays set and stays quiet when detection is off, and completion sets the done flag. Only the bench scenarios can show the bit-exact serial content: the break length for each count, the delimiter, the framing and bit order of the sync byte, the parity of each computed identifier, and how the select codes map to header kinds. The same holds for the number of ticks before the trigger drops, and for the error flag being raised by a forced read-back mismatch and then cleared by a write of 1.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    // Header content phases on the wire
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BREAK,
        PH_DELIM,
        PH_SYNC,
        PH_PID
    } phase_e;

    // Header composition after decoding the select field
    typedef enum logic [1:0] {
        HK_BRK      = 2'd0,
        HK_BRK_SYNC = 2'd1,
        HK_FULL     = 2'd2
    } hdr_kind_e;

    localparam int BRK_EXT_W  = 3;
    localparam int ID_W       = 6;
    localparam int BRK_BASE   = 8;
    localparam int FRAME_BITS = 10;
    localparam int CNT_W      = 4;
    localparam logic [7:0] SYNC_BYTE = 8'h55;

    // Configuration captured when a header starts
    typedef struct packed {
        logic [BRK_EXT_W-1:0] brk_ext;
        hdr_kind_e            kind;
        logic [ID_W-1:0]      ident;
    } hdr_cfg_t;

    // Code 11 is folded onto the full header
    function automatic hdr_kind_e decode_sel(input logic [1:0] sel);
        case (sel)
            2'b00:   return HK_BRK;
            2'b01:   return HK_BRK_SYNC;
            default: return HK_FULL;
        endcase
    endfunction

    // Protected identifier: two parity bits above the six ID bits
    function automatic logic [7:0] make_pid(input logic [ID_W-1:0] id);
        logic p0;
        logic p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0, id};
    endfunction

    // Start bit in position 0, stop bit on top, shifted out from bit 0
    function automatic logic [FRAME_BITS-1:0] make_frame(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

endpackage

// File: rtl/lin_bit_timer.sv
module lin_bit_timer #(
    parameter int OVS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic mid_pt,
    output logic bit_end
);
    localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [SUB_W-1:0] LAST = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] MID  = SUB_W'(OVS / 2);

    logic [SUB_W-1:0] sub_q;

    // Sub-bit position; held at zero whenever no header is in flight
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sub_q <= '0;
        end else if (tick) begin
            sub_q <= (sub_q == LAST) ? '0 : sub_q + 1'b1;
        end
    end

    assign mid_pt  = run && tick && (sub_q == MID);
    assign bit_end = run && tick && (sub_q == LAST);

    AST_SUB_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(sub_q) < OVS); // R2

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
    import lin_hdr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_req,
    input  hdr_cfg_t cfg_in,
    input  logic     bit_end,
    output logic     busy,
    output logic     txd,
    output logic     finish
);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);

    phase_e                phase_q, phase_d;
    hdr_cfg_t              cfg_q, cfg_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic [FRAME_BITS-1:0] sh_q, sh_d;
    logic [CNT_W-1:0]      brk_last;

    assign brk_last = CNT_W'(BRK_BASE - 1) + {1'b0, cfg_q.brk_ext};

    always_comb begin
        phase_d = phase_q;
        cfg_d   = cfg_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        finish  = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (start_req) begin
                    phase_d = PH_BREAK;
                    cfg_d   = cfg_in;
                    cnt_d   = '0;
                end
            end
            PH_BREAK: begin
                if (bit_end) begin
                    if (cnt_q == brk_last) begin
                        cnt_d = '0;
                        if (cfg_q.kind == HK_BRK) begin
                            phase_d = PH_IDLE;
                            finish  = 1'b1;
                        end else begin
                            phase_d = PH_DELIM;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PH_DELIM: begin
                if (bit_end) begin
                    phase_d = PH_SYNC;
                    sh_d    = make_frame(SYNC_BYTE);
                    cnt_d   = '0;
                end
            end
            PH_SYNC, PH_PID: begin
                if (bit_end) begin
                    if (cnt_q == FRAME_LAST) begin
                        cnt_d = '0;
                        if (phase_q == PH_SYNC && cfg_q.kind == HK_FULL) begin
                            phase_d = PH_PID;
                            sh_d    = make_frame(make_pid(cfg_q.ident));
                        end else begin
                            phase_d = PH_IDLE;
                            sh_d    = '1;
                            finish  = 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                        sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cfg_q   <= '0;
            cnt_q   <= '0;
            sh_q    <= '1;
        end else begin
            phase_q <= phase_d;
            cfg_q   <= cfg_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
        end
    end

    assign busy = (phase_q != PH_IDLE);

    always_comb begin
        case (phase_q)
            PH_BREAK:        txd = 1'b0;
            PH_SYNC, PH_PID: txd = sh_q[0];
            default:         txd = 1'b1;
        endcase
    end

    AST_BRK_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BREAK) |-> (cnt_q <= brk_last)); // R2

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && start_req) |=> $stable(cfg_q)); // R7

    AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SYNC || phase_q == PH_PID) |-> (cnt_q <= FRAME_LAST)); // R4

endmodule

// File: rtl/lin_bit_monitor.sv
module lin_bit_monitor (
    input  logic clk,
    input  logic rst,
    input  logic mid_pt,
    input  logic berr_en,
    input  logic rxd,
    input  logic txd,
    input  logic finish,
    input  logic clr_done,
    input  logic clr_berr,
    output logic done,
    output logic berr
);
    logic done_q;
    logic berr_q;
    logic mismatch;

    // mid_pt only fires while a header is in flight
    assign mismatch = berr_en && mid_pt && (rxd != txd);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            berr_q <= 1'b0;
        end else begin
            if (finish)        done_q <= 1'b1;
            else if (clr_done) done_q <= 1'b0;
            if (mismatch)      berr_q <= 1'b1;
            else if (clr_berr) berr_q <= 1'b0;
        end
    end

    assign done = done_q;
    assign berr = berr_q;

    AST_BERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(berr_q) && !$past(clr_berr)) |-> berr_q); // R8

    AST_BERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$past(berr_q) && !$past(berr_en)) |-> !berr_q); // R9

    AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
        $past(finish) |-> done_q); // R6

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
    import lin_hdr_pkg::*;
#(
    parameter int OVS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       start_wr,
    input  logic [1:0] hdr_sel,
    input  logic [2:0] brk_ext,
    input  logic [5:0] ident,
    input  logic       berr_en,
    input  logic       clr_done,
    input  logic       clr_berr,
    input  logic       rxd,
    output logic       txd,
    output logic       trig,
    output logic       done,
    output logic       berr
);
    hdr_cfg_t cfg_in;
    logic     busy;
    logic     mid_pt;
    logic     bit_end;
    logic     finish;
    logic     line;

    assign cfg_in = '{brk_ext: brk_ext, kind: decode_sel(hdr_sel), ident: ident};

    lin_bit_timer #(.OVS(OVS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .tick    (baud_tick),
        .mid_pt  (mid_pt),
        .bit_end (bit_end)
    );

    lin_hdr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_wr),
        .cfg_in    (cfg_in),
        .bit_end   (bit_end),
        .busy      (busy),
        .txd       (line),
        .finish    (finish)
    );

    lin_bit_monitor u_mon (
        .clk      (clk),
        .rst      (rst),
        .mid_pt   (mid_pt),
        .berr_en  (berr_en),
        .rxd      (rxd),
        .txd      (line),
        .finish   (finish),
        .clr_done (clr_done),
        .clr_berr (clr_berr),
        .done     (done),
        .berr     (berr)
    );

    assign txd  = line;
    assign trig = busy;

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !trig |-> txd); // R11

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!trig && start_wr) |=> trig); // R6

endmodule

// File: tb/lin_hdr_tx_bench.sv
module lin_hdr_tx_bench;
    localparam int OVS = 4;
    localparam logic [7:0] SYNC = 8'h55;

    typedef struct packed {
        logic [1:0] sel;
        logic [2:0] brk;
        logic [5:0] id;
        logic [7:0] pid;
        logic       poke;
    } vec_t;

    // Expected PIDs worked out by hand from the parity equations
    localparam vec_t VECS [8] = '{
        '{2'd2, 3'd0, 6'h00, 8'h80, 1'b0},
        '{2'd2, 3'd7, 6'h3C, 8'h3C, 1'b1},
        '{2'd3, 3'd3, 6'h01, 8'hC1, 1'b0},
        '{2'd1, 3'd5, 6'h3F, 8'hBF, 1'b1},
        '{2'd0, 3'd0, 6'h12, 8'h92, 1'b0},
        '{2'd0, 3'd7, 6'h05, 8'h00, 1'b1},
        '{2'd2, 3'd1, 6'h12, 8'h92, 1'b0},
        '{2'd2, 3'd4, 6'h3F, 8'hBF, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic baud_tick = 1'b0;
    logic start_wr = 1'b0;
    logic [1:0] hdr_sel = 2'd0;
    logic [2:0] brk_ext = 3'd0;
    logic [5:0] ident = 6'd0;
    logic berr_en = 1'b0;
    logic clr_done = 1'b0;
    logic clr_berr = 1'b0;
    logic force_on = 1'b0;
    logic rxd;
    logic txd, trig, done, berr;

    int total = 0;
    int fails = 0;

    assign rxd = force_on ? 1'b1 : txd;

    always #10 clk = ~clk;

    lin_hdr_tx #(.OVS(OVS)) u_lin_hdr_tx (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .start_wr(start_wr),
        .hdr_sel(hdr_sel), .brk_ext(brk_ext), .ident(ident), .berr_en(berr_en),
        .clr_done(clr_done), .clr_berr(clr_berr), .rxd(rxd),
        .txd(txd), .trig(trig), .done(done), .berr(berr)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); baud_tick = 1'b1;
            @(negedge clk); baud_tick = 1'b0;
        end
    endtask

    // Sends one header, sampling txd once per bit; poke issues a rival start
    task automatic run_hdr(input vec_t v, input int stop_at, output logic [63:0] got,
                           output logic [63:0] exp, output bit busy_ok);
        int n;
        n = 0; exp = '0; got = '0; busy_ok = 1'b1;
        for (int i = 0; i < int'(v.brk) + 8; i++) begin exp[n] = 1'b0; n++; end
        if (v.sel != 2'd0) begin
            exp[n] = 1'b1; n++;
            exp[n] = 1'b0; n++;
            for (int i = 0; i < 8; i++) begin exp[n] = SYNC[i]; n++; end
            exp[n] = 1'b1; n++;
        end
        if (v.sel[1]) begin
            exp[n] = 1'b0; n++;
            for (int i = 0; i < 8; i++) begin exp[n] = v.pid[i]; n++; end
            exp[n] = 1'b1; n++;
        end
        @(negedge clk);
        hdr_sel = v.sel; brk_ext = v.brk; ident = v.id; start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        for (int t = 0; t < n * OVS; t++) begin
            if (t == stop_at) begin
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                return;
            end
            baud_tick = 1'b1;
            if (v.poke && t == 9) begin
                start_wr = 1'b1; hdr_sel = 2'd0; brk_ext = ~v.brk; ident = ~v.id;
            end
            if (t % OVS == 1) got[t / OVS] = txd;
            if (!trig) busy_ok = 1'b0;
            @(negedge clk);
            baud_tick = 1'b0; start_wr = 1'b0;
            hdr_sel = v.sel; brk_ext = v.brk; ident = v.id;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [63:0] got, exp;
        bit busy_ok;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd && !trig && !done && !berr, "R1 reset state",
            {txd, trig, done, berr}, 4'b1000);

        // Idle ticks with a mismatching read-back: no motion, no flag
        berr_en = 1'b1; force_on = 1'b1;
        idle_ticks(12);
        chk(txd && !trig && !berr, "R11 R9 idle ticks ignored",
            {txd, trig, berr}, 3'b100);
        force_on = 1'b0;

        // Table of header vectors with loopback read-back and detection on
        foreach (VECS[k]) begin
            run_hdr(VECS[k], -1, got, exp, busy_ok);
            if (VECS[k].sel == 2'd0)      tag = "R2 R3 break only";
            else if (VECS[k].sel == 2'd1) tag = "R2 R4 break+sync";
            else if (VECS[k].sel == 2'd3) tag = "R3 R5 code 11";
            else                          tag = "R2 R5 full header";
            if (VECS[k].poke) tag = {tag, " R7 rival start"};
            chk(got == exp, tag, got, exp);
            chk(busy_ok && !trig && done, "R6 trig held then cleared, done set",
                {busy_ok, trig, done}, 3'b101);
            chk(!berr, "R8 no error on clean loopback", berr, 0);
        end

        // Write-1 clear of done
        @(negedge clk); clr_done = 1'b1;
        @(negedge clk); clr_done = 1'b0;
        chk(!done, "R10 done cleared", done, 0);

        // Forced mismatch with detection enabled
        berr_en = 1'b1; force_on = 1'b1;
        run_hdr('{2'd0, 3'd0, 6'h00, 8'h00, 1'b0}, -1, got, exp, busy_ok);
        force_on = 1'b0;
        chk(berr, "R8 mismatch sets berr", berr, 1);
        idle_ticks(3);
        chk(berr, "R8 berr sticky", berr, 1);
        @(negedge clk); clr_berr = 1'b1;
        @(negedge clk); clr_berr = 1'b0;
        chk(!berr, "R10 berr cleared", berr, 0);

        // Forced mismatch with detection disabled
        berr_en = 1'b0; force_on = 1'b1;
        run_hdr('{2'd1, 3'd2, 6'h00, 8'h00, 1'b0}, -1, got, exp, busy_ok);
        force_on = 1'b0;
        chk(!berr, "R9 detection off", berr, 0);
        chk(done, "R6 done after header", done, 1);

        // Reset in the middle of a header
        run_hdr('{2'd2, 3'd3, 6'h2A, 8'h00, 1'b0}, 50, got, exp, busy_ok);
        chk(txd && !trig && !done && !berr, "R1 reset mid-header",
            {txd, trig, done, berr}, 4'b1000);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule